// File: doc/BRIEF.md
# Parity-Protected Dual-Port Word Memory

This block is a synchronous memory of 1024 nine-bit words (9216 bits). Eight bits of each word carry data and the ninth holds an even-parity bit, so the usable data capacity is 8192 bits. Two ports, A and B, each have their own address, write data, read data, read enable and write enable. The ports may read or write any location at the same time. This makes the array a suitable store for RAM, ROM-like lookup, delay-line or FIFO use by surrounding logic.

A build-time layout parameter selects one of two arrangements. In the shared arrangement, both ports see the whole array. In the split arrangement, the array becomes two isolated single-port memories of 512 words each: port A only reaches the lower half and port B only the upper half. The parity bit is generated on every write. It is checked on every registered read, and a mismatch raises a per-port error flag.

Both ports run on a single clock, `clk`. A synchronous active-low reset clears the read registers and error flags but leaves the array contents unchanged.

Top module: `parity_dual_ram`

## Requirements
- R1: With default parameters, the array holds 2^10 words, each with 8 data bits plus 1 parity bit. Every address from 0x000 to 0x3FF can be written and read back independently.
- R2: A read is registered. When a port's read enable is high at a rising edge, that port's data output shows the addressed word's data bits after that edge, with one cycle of latency.
- R3: While a port's read enable is low, its data output and error flag keep their previous values, even if that port writes in the same cycle.
- R4: A port's write enable stores its data input at its address on the rising edge, independently of its read enable. A following read returns the new value.
- R5: If a port reads and writes the same address in one cycle, its output shows the data stored before the write (read-before-write).
- R6: In the shared layout, data written through one port is readable through the other. A read through one port at an address that the other port writes in the same cycle returns the old data.
- R7: On write, the stored bit 8 is the XOR of data bits 7..0, so each word holds an even number of ones. On read, the error flag is set when the stored 9-bit word has an odd number of ones. For any data written through the ports, the flag stays low.
- R8: In the split layout, port A's top address bit is forced to 0 and port B's top address bit is forced to 1. Each port's top address input bit is therefore ignored, and a write from one port is never visible to the other.
- R9: While rst_n is low at a rising edge, both data outputs and both error flags become 0. The array contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read registers |
| a_addr | input | 10 | Port A word address |
| a_din | input | 8 | Port A write data |
| a_we | input | 1 | Port A write enable |
| a_re | input | 1 | Port A read enable |
| a_dout | output | 8 | Port A registered read data |
| a_perr | output | 1 | Port A parity error flag, registered with the read |
| b_addr | input | 10 | Port B word address |
| b_din | input | 8 | Port B write data |
| b_we | input | 1 | Port B write enable |
| b_re | input | 1 | Port B read enable |
| b_dout | output | 8 | Port B registered read data |
| b_perr | output | 1 | Port B parity error flag, registered with the read |

## Verification
The array itself is not observable, so any corrupted word or wrong address mapping only becomes visible on a data output one cycle after a read enable. A wrong parity bit shows as the error flag rising in that same read cycle. An aliasing fault in the split layout shows only when the other port reads the affected location, so the stimulus writes through one port and reads back through both. A read register that updates without its enable changes the output on the very next edge, even when no read was requested.

// File: rtl/parity_dual_ram_pkg.sv
// Package: shared layout selector and default geometry for the parity memory.
// Assumes: a data byte plus one parity bit per word.
package parity_dual_ram_pkg;

    // Array arrangement chosen at build time
    typedef enum logic {
        LAYOUT_SHARED = 1'b0,
        LAYOUT_SPLIT  = 1'b1
    } layout_e;

    localparam int unsigned DEF_ADDR_W = 10;
    localparam int unsigned DEF_DATA_W = 8;

endpackage

// File: rtl/dpram_addr_map.sv
// Module: maps a port address onto the physical array.
// Forces the top bit to FORCE_VAL when FORCE_HI is set (split layout),
// otherwise passes the address through. Purely combinational.
module dpram_addr_map #(
    parameter int unsigned ADDR_W    = 10,
    parameter bit          FORCE_HI  = 1'b0,
    parameter logic        FORCE_VAL = 1'b0
) (
    input  logic [ADDR_W-1:0] port_addr,
    output logic [ADDR_W-1:0] phys_addr
);

    generate
        if (FORCE_HI) begin : g_forced
            // top bit pinned to this port's half
            assign phys_addr = {FORCE_VAL, port_addr[ADDR_W-2:0]};
        end else begin : g_pass
            // whole array reachable
            assign phys_addr = port_addr;
        end
    endgenerate

endmodule

// File: rtl/dpram_store.sv
// Module: storage array with two write ports and two asynchronous read taps.
// Assumes: both ports share one clock; simultaneous writes to one word are
// avoided by the user (port B lands last, but the result is not guaranteed).
module dpram_store #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned WORD_W = 9
) (
    input  logic              clk,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_idx,
    input  logic [WORD_W-1:0] a_wword,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_idx,
    input  logic [WORD_W-1:0] b_wword,
    output logic [WORD_W-1:0] a_rword,
    output logic [WORD_W-1:0] b_rword
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    // Store words presented by either port on the rising edge
    always_ff @(posedge clk) begin
        if (a_wr) begin
            cells[a_idx] <= a_wword;
        end
        if (b_wr) begin
            cells[b_idx] <= b_wword;
        end
    end

    // Current contents seen by each port (old data during a write)
    assign a_rword = cells[a_idx];
    assign b_rword = cells[b_idx];

endmodule

// File: rtl/dpram_read_reg.sv
// Module: per-port read register with parity check.
// Captures data bits and an odd-parity error flag when rd_en is high;
// holds otherwise. Synchronous active-low reset clears both.
module dpram_read_reg #(
    parameter int unsigned WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] rword,
    output logic [WORD_W-2:0] rdata,
    output logic              rerr
);

    // Register the read word and flag a parity mismatch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            rerr  <= 1'b0;
        end else if (rd_en) begin
            rdata <= rword[WORD_W-2:0];
            rerr  <= ^rword;
        end
    end

endmodule

// File: rtl/parity_dual_ram.sv
// Module: parity-protected dual-port word memory (top).
// Generates even parity on write, checks it on registered read, and
// optionally splits the array into two private halves, one per port.
// Assumes: single clock for both ports; no same-word dual write.
module parity_dual_ram
    import parity_dual_ram_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter layout_e     LAYOUT = LAYOUT_SHARED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_din,
    input  logic              a_we,
    input  logic              a_re,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_perr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_din,
    input  logic              b_we,
    input  logic              b_re,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_perr
);

    localparam int unsigned WORD_W = DATA_W + 1;
    localparam bit          SPLIT  = (LAYOUT == LAYOUT_SPLIT);

    logic [ADDR_W-1:0] a_phys, b_phys;
    logic [WORD_W-1:0] a_wword, b_wword;
    logic [WORD_W-1:0] a_rword, b_rword;

    // Even parity: bit 8 makes the word's ones count even
    assign a_wword = {^a_din, a_din};
    assign b_wword = {^b_din, b_din};

    dpram_addr_map #(
        .ADDR_W   (ADDR_W),
        .FORCE_HI (SPLIT),
        .FORCE_VAL(1'b0)
    ) map_a_i (
        .port_addr(a_addr),
        .phys_addr(a_phys)
    );

    dpram_addr_map #(
        .ADDR_W   (ADDR_W),
        .FORCE_HI (SPLIT),
        .FORCE_VAL(1'b1)
    ) map_b_i (
        .port_addr(b_addr),
        .phys_addr(b_phys)
    );

    dpram_store #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W)
    ) store_i (
        .clk    (clk),
        .a_wr   (a_we),
        .a_idx  (a_phys),
        .a_wword(a_wword),
        .b_wr   (b_we),
        .b_idx  (b_phys),
        .b_wword(b_wword),
        .a_rword(a_rword),
        .b_rword(b_rword)
    );

    dpram_read_reg #(
        .WORD_W(WORD_W)
    ) rreg_a_i (
        .clk  (clk),
        .rst_n(rst_n),
        .rd_en(a_re),
        .rword(a_rword),
        .rdata(a_dout),
        .rerr (a_perr)
    );

    dpram_read_reg #(
        .WORD_W(WORD_W)
    ) rreg_b_i (
        .clk  (clk),
        .rst_n(rst_n),
        .rd_en(b_re),
        .rword(b_rword),
        .rdata(b_dout),
        .rerr (b_perr)
    );

endmodule

// File: rtl/parity_dual_ram_chk.sv
// Module: assertion checker for parity_dual_ram, bound to every instance.
// Observes only the top-level ports.
module parity_dual_ram_chk #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_din,
    input logic              a_we,
    input logic              a_re,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_perr,
    input logic              b_we,
    input logic              b_re,
    input logic [DATA_W-1:0] b_dout,
    input logic              b_perr
);

    logic [1:0] since_rst;

    // Count cycles since reset so that history lookups stay after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R3
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_re |=> ($stable(a_dout) && $stable(a_perr)));

    // R3
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_re |=> ($stable(b_dout) && $stable(b_perr)));

    // R7
    a_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_perr);

    // R7
    b_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_perr);

    // R4
    a_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && a_re && $past(a_we) && a_addr == $past(a_addr)
         && !b_we && !$past(b_we)) |=> (a_dout == $past(a_din, 2)));

endmodule

bind parity_dual_ram parity_dual_ram_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .a_addr(a_addr),
    .a_din (a_din),
    .a_we  (a_we),
    .a_re  (a_re),
    .a_dout(a_dout),
    .a_perr(a_perr),
    .b_we  (b_we),
    .b_re  (b_re),
    .b_dout(b_dout),
    .b_perr(b_perr)
);

// File: tb/parity_dual_ram_tb_top.sv
// Bench: vector table on the shared-layout instance, then directed reset
// and split-layout tests on a second instance.
module parity_dual_ram_tb_top;
    import parity_dual_ram_pkg::*;

    typedef struct packed {
        logic       awe;
        logic       are;
        logic [9:0] aad;
        logic [7:0] adi;
        logic       bwe;
        logic       bre;
        logic [9:0] bad;
        logic [7:0] bdi;
        logic [7:0] ea;
        logic [7:0] eb;
    } vec_t;

    // Expected outputs are the values after the vector's rising edge
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 10'h000, 8'h5A, 1'b1, 1'b0, 10'h3FF, 8'hC3, 8'h00, 8'h00},
        '{1'b0, 1'b1, 10'h3FF, 8'h00, 1'b0, 1'b1, 10'h000, 8'h00, 8'hC3, 8'h5A},
        '{1'b1, 1'b1, 10'h000, 8'h11, 1'b0, 1'b0, 10'h000, 8'h00, 8'h5A, 8'h5A},
        '{1'b0, 1'b1, 10'h000, 8'h00, 1'b0, 1'b1, 10'h000, 8'h00, 8'h11, 8'h11},
        '{1'b0, 1'b0, 10'h000, 8'h00, 1'b1, 1'b1, 10'h3FF, 8'hFF, 8'h11, 8'hC3},
        '{1'b0, 1'b1, 10'h3FF, 8'h00, 1'b0, 1'b1, 10'h3FF, 8'h00, 8'hFF, 8'hFF},
        '{1'b1, 1'b0, 10'h155, 8'h00, 1'b1, 1'b0, 10'h2AA, 8'h80, 8'hFF, 8'hFF},
        '{1'b0, 1'b1, 10'h2AA, 8'h00, 1'b0, 1'b1, 10'h155, 8'h00, 8'h80, 8'h00},
        '{1'b1, 1'b0, 10'h000, 8'h22, 1'b0, 1'b1, 10'h000, 8'h00, 8'h80, 8'h11},
        '{1'b0, 1'b1, 10'h000, 8'h00, 1'b0, 1'b1, 10'h000, 8'h00, 8'h22, 8'h22}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] a_addr = '0, b_addr = '0, pa_addr = '0, pb_addr = '0;
    logic [7:0] a_din = '0, b_din = '0, pa_din = '0, pb_din = '0;
    logic       a_we = 1'b0, a_re = 1'b0, b_we = 1'b0, b_re = 1'b0;
    logic       pa_we = 1'b0, pa_re = 1'b0, pb_we = 1'b0, pb_re = 1'b0;
    logic [7:0] a_dout, b_dout, pa_dout, pb_dout;
    logic       a_perr, b_perr, pa_perr, pb_perr;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    parity_dual_ram #(.LAYOUT(LAYOUT_SHARED)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_din(a_din), .a_we(a_we), .a_re(a_re),
        .a_dout(a_dout), .a_perr(a_perr),
        .b_addr(b_addr), .b_din(b_din), .b_we(b_we), .b_re(b_re),
        .b_dout(b_dout), .b_perr(b_perr)
    );

    parity_dual_ram #(.LAYOUT(LAYOUT_SPLIT)) dut_pk_i (
        .clk(clk), .rst_n(rst_n),
        .a_addr(pa_addr), .a_din(pa_din), .a_we(pa_we), .a_re(pa_re),
        .a_dout(pa_dout), .a_perr(pa_perr),
        .b_addr(pb_addr), .b_din(pb_din), .b_we(pb_we), .b_re(pb_re),
        .b_dout(pb_dout), .b_perr(pb_perr)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One split-layout cycle: drive at negedge, sample 5 ns after posedge
    task automatic pk_step(input logic awe, input logic are, input logic [9:0] aad,
                           input logic [7:0] adi, input logic bwe, input logic bre,
                           input logic [9:0] bad, input logic [7:0] bdi);
        @(negedge clk);
        pa_we = awe; pa_re = are; pa_addr = aad; pa_din = adi;
        pb_we = bwe; pb_re = bre; pb_addr = bad; pb_din = bdi;
        @(posedge clk);
        #5;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R9 reset state
        check("R9 a_dout reset", a_dout, 8'h00);
        check("R9 b_dout reset", b_dout, 8'h00);
        check("R9 a_perr reset", {7'b0, a_perr}, 8'h00);
        check("R9 b_perr reset", {7'b0, b_perr}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R7 vector walk on the shared layout
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a_we = VECS[i].awe; a_re = VECS[i].are; a_addr = VECS[i].aad; a_din = VECS[i].adi;
            b_we = VECS[i].bwe; b_re = VECS[i].bre; b_addr = VECS[i].bad; b_din = VECS[i].bdi;
            @(posedge clk);
            #5;
            check($sformatf("R2/R3/R5/R6 vec %0d port A", i), a_dout, VECS[i].ea);
            check($sformatf("R2/R3/R5/R6 vec %0d port B", i), b_dout, VECS[i].eb);
            check($sformatf("R7 vec %0d a_perr", i), {7'b0, a_perr}, 8'h00);
            check($sformatf("R7 vec %0d b_perr", i), {7'b0, b_perr}, 8'h00);
        end

        // R9 reset with reads enabled clears outputs, contents survive
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0; a_re = 1'b1; b_re = 1'b1;
        a_addr = 10'h000; b_addr = 10'h3FF;
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        check("R9 a_dout cleared", a_dout, 8'h00);
        check("R9 b_dout cleared", b_dout, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check("R9 contents kept A", a_dout, 8'h22);
        check("R9 contents kept B R1", b_dout, 8'hFF);
        @(negedge clk);
        a_re = 1'b0; b_re = 1'b0;

        // R8 split layout: top address bit forced per port
        pk_step(1'b1, 1'b0, 10'h3FF, 8'h3C, 1'b1, 1'b0, 10'h005, 8'h96);
        pk_step(1'b1, 1'b0, 10'h005, 8'h69, 1'b1, 1'b0, 10'h1FF, 8'hA5);
        pk_step(1'b0, 1'b1, 10'h1FF, 8'h00, 1'b0, 1'b1, 10'h205, 8'h00);
        check("R8 A top bit ignored", pa_dout, 8'h3C);
        check("R8 B top bit ignored", pb_dout, 8'h96);
        pk_step(1'b0, 1'b1, 10'h205, 8'h00, 1'b0, 1'b1, 10'h005, 8'h00);
        check("R8 A private low half", pa_dout, 8'h69);
        check("R8 B unaffected by A write", pb_dout, 8'h96);
        pk_step(1'b0, 1'b1, 10'h3FF, 8'h00, 1'b0, 1'b1, 10'h3FF, 8'h00);
        check("R8 A unaffected by B write", pa_dout, 8'h3C);
        check("R8 B private high half", pb_dout, 8'hA5);
        check("R7 split a_perr", {7'b0, pa_perr}, 8'h00);
        check("R7 split b_perr", {7'b0, pb_perr}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule